// File: doc/BRIEF.md
# Selectable-Polynomial Byte CRC Engine

This block keeps a running cyclic redundancy checksum over a byte stream of any length. Each cycle in which the byte strobe is high, one full 8-bit step of the polynomial division is applied to the stored checksum. One engine serves three generator polynomials: one 8-bit and two 16-bit. Each can run in either bit order, so the checksum can match a serial link that sends the most significant bit first or the least significant bit first.

Software-style control is reduced to strobes. A configuration write selects the polynomial and the bit order. A seed write loads a starting value. A clear strobe zeroes the checksum. The current checksum is always visible on the result port, so a caller streams bytes and reads the result in the cycle after the last byte.

Top module: `crcByteEngine`

## Requirements
- R1: After reset the result is 0x0000, the polynomial code is 0 and the bit order is MSB-first.
- R2: With `cfgLsbFirst`=0, each byte is folded into the top of the register and shifted left eight times. Code 0 uses x^8+x^2+x+1 (0x07, 8-bit register), code 1 uses x^16+x^15+x^2+1 (0x8005) and code 2 uses x^16+x^12+x^5+1 (0x1021). For the ASCII bytes "123456789" from a zero start, the results are 0x00F4, 0xFEE8 and 0x31C3.
- R3: With `cfgLsbFirst`=1, each byte is XORed into bit 0 and shifted right eight times, using the reflected constants 0xE0, 0xA001 and 0x8408 for codes 0, 1 and 2. For "123456789" from zero, code 1 gives 0xBB3D and code 2 gives 0x2189.
- R4: A byte presented with `byteValid` high is fully applied at that clock edge, and the new value shows on `result` after that edge. Bytes on consecutive cycles are each consumed.
- R5: `seedWrite` loads `seedData` into the checksum. Under code 0 only bits 7:0 are kept and the upper byte becomes zero. Seeding 0xFFFF under code 2 MSB-first and then feeding "123456789" gives 0x29B1.
- R6: `clearReq` sets the checksum to zero at the next edge.
- R7: While code 0 is active, `result[15:8]` is always zero.
- R8: A configuration write whose code or bit order differs from the active one applies the new setting and zeroes the checksum. A write that repeats the active setting leaves the checksum unchanged.
- R9: A configuration write with code 3 is ignored. The active setting and the checksum both stay as they were.
- R10: When strobes coincide, clear or a configuration change wins over a seed write, and a seed write wins over a byte. The losing actions are dropped.
- R11: In a cycle with no strobe, the result holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clearReq | input | 1 | Zero the checksum |
| cfgWrite | input | 1 | Write polynomial code and bit order |
| cfgPoly | input | 2 | Polynomial code: 0 8-bit, 1 0x8005, 2 0x1021, 3 ignored |
| cfgLsbFirst | input | 1 | 1 selects LSB-first (reflected) order |
| seedWrite | input | 1 | Load `seedData` into the checksum |
| seedData | input | 16 | Seed value |
| byteValid | input | 1 | Apply `byteData` this cycle |
| byteData | input | 8 | Data byte |
| result | output | 16 | Current checksum |

## Verification
The whole state is the checksum register plus a three-bit configuration. A wrong checksum bit therefore shows on `result` in the very next cycle. A wrongly held polynomial or bit order shows one cycle after the next byte, because that step diverges from a bit-serial reference.

The bench compares `result` against such a reference on every clock, including random streams with random reconfiguration. A stale or misapplied configuration is caught through the clear it should or should not have caused, and through the following byte step.

// File: rtl/crcEnginePkg.sv
package crcEnginePkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    POLY_C8   = 2'd0,
    POLY_A16  = 2'd1,
    POLY_K16  = 2'd2,
    POLY_RSVD = 2'd3
  } polySelT;

  typedef struct packed {
    polySelT poly;
    logic    lsbFirst;
  } crcCfgT;

  typedef struct packed {
    logic clr;
    logic load;
    logic step;
  } crcStrobeT;

  function automatic logic [CRC_W-1:0] polyNormal(polySelT sel);
    case (sel)
      POLY_A16: polyNormal = 16'h8005;
      POLY_K16: polyNormal = 16'h1021;
      default:  polyNormal = 16'h0007;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] polyReflected(polySelT sel);
    case (sel)
      POLY_A16: polyReflected = 16'hA001;
      POLY_K16: polyReflected = 16'h8408;
      default:  polyReflected = 16'h00E0;
    endcase
  endfunction
endpackage

// File: rtl/crcCtrl.sv
module crcCtrl
  import crcEnginePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearReq,
  input  logic       cfgWrite,
  input  logic [1:0] cfgPoly,
  input  logic       cfgLsbFirst,
  input  logic       seedWrite,
  input  logic       byteValid,
  output crcCfgT     cfg,
  output crcStrobeT  strobe
);
  crcCfgT cfgQ;
  logic   cfgAccept;
  logic   cfgDiffers;
  logic   zeroNow;

  assign cfgAccept  = cfgWrite && (polySelT'(cfgPoly) != POLY_RSVD);
  assign cfgDiffers = cfgAccept &&
                      ((polySelT'(cfgPoly) != cfgQ.poly) || (cfgLsbFirst != cfgQ.lsbFirst));
  assign zeroNow    = clearReq || cfgDiffers;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.poly     <= POLY_C8;
      cfgQ.lsbFirst <= 1'b0;
    end else if (cfgAccept) begin
      cfgQ.poly     <= polySelT'(cfgPoly);
      cfgQ.lsbFirst <= cfgLsbFirst;
    end
  end

  always_comb begin
    strobe.clr  = zeroNow;
    strobe.load = !zeroNow && seedWrite;
    strobe.step = !zeroNow && !seedWrite && byteValid;
  end

  assign cfg = cfgQ;
endmodule

// File: rtl/crcDatapath.sv
module crcDatapath
  import crcEnginePkg::*;
#(
  parameter int unsigned REG_W  = CRC_W,
  parameter int unsigned BYTE_W = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcCfgT            cfg,
  input  crcStrobeT         strobe,
  input  logic [REG_W-1:0]  seedData,
  input  logic [BYTE_W-1:0] byteData,
  output logic [REG_W-1:0]  crcOut
);
  localparam int unsigned PAD = REG_W - BYTE_W;
  localparam logic [REG_W-1:0] NARROW_MASK = {{PAD{1'b0}}, {BYTE_W{1'b1}}};

  logic [REG_W-1:0]  crcQ;
  logic [REG_W-1:0]  stepVal;
  logic [REG_W-1:0]  loadVal;
  logic [BYTE_W-1:0] narrowVal;
  logic [REG_W-1:0]  polyNorm;
  logic [REG_W-1:0]  polyRefl;
  logic              isWide;

  assign isWide   = (cfg.poly != POLY_C8);
  assign polyNorm = polyNormal(cfg.poly);
  assign polyRefl = polyReflected(cfg.poly);
  assign loadVal  = isWide ? seedData : (seedData & NARROW_MASK);

  always_comb begin
    stepVal   = crcQ;
    narrowVal = '0;
    if (cfg.lsbFirst) begin
      stepVal = crcQ ^ {{PAD{1'b0}}, byteData};
      for (int i = 0; i < BYTE_W; i++) begin
        stepVal = stepVal[0] ? ((stepVal >> 1) ^ polyRefl) : (stepVal >> 1);
      end
    end else if (isWide) begin
      stepVal = crcQ ^ ({{PAD{1'b0}}, byteData} << PAD);
      for (int i = 0; i < BYTE_W; i++) begin
        stepVal = stepVal[REG_W-1] ? ((stepVal << 1) ^ polyNorm) : (stepVal << 1);
      end
    end else begin
      narrowVal = crcQ[BYTE_W-1:0] ^ byteData;
      for (int i = 0; i < BYTE_W; i++) begin
        narrowVal = narrowVal[BYTE_W-1] ?
                    ((narrowVal << 1) ^ polyNorm[BYTE_W-1:0]) : (narrowVal << 1);
      end
      stepVal = {{PAD{1'b0}}, narrowVal};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ <= '0;
    end else if (strobe.clr) begin
      crcQ <= '0;
    end else if (strobe.load) begin
      crcQ <= loadVal;
    end else if (strobe.step) begin
      crcQ <= stepVal;
    end
  end

  assign crcOut = crcQ;
endmodule

// File: rtl/crcByteEngine.sv
module crcByteEngine
  import crcEnginePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clearReq,
  input  logic         cfgWrite,
  input  logic [1:0]   cfgPoly,
  input  logic         cfgLsbFirst,
  input  logic         seedWrite,
  input  logic [15:0]  seedData,
  input  logic         byteValid,
  input  logic [7:0]   byteData,
  output logic [15:0]  result
);
  crcCfgT    cfgQ;
  crcStrobeT strobe;

  crcCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clearReq   (clearReq),
    .cfgWrite   (cfgWrite),
    .cfgPoly    (cfgPoly),
    .cfgLsbFirst(cfgLsbFirst),
    .seedWrite  (seedWrite),
    .byteValid  (byteValid),
    .cfg        (cfgQ),
    .strobe     (strobe)
  );

  crcDatapath #(
    .REG_W (CRC_W),
    .BYTE_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfgQ),
    .strobe  (strobe),
    .seedData(seedData),
    .byteData(byteData),
    .crcOut  (result)
  );
endmodule

// File: rtl/crcByteEngineChk.sv
module crcByteEngineChk
  import crcEnginePkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        clearReq,
  input logic        cfgWrite,
  input logic [1:0]  cfgPoly,
  input logic        cfgLsbFirst,
  input logic        seedWrite,
  input logic [15:0] seedData,
  input logic        byteValid,
  input logic [15:0] result,
  input crcCfgT      cfgNow
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (result == 16'h0000)); // R6

  AST_CFG_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgPoly != 2'd3 &&
     (cfgPoly != cfgNow.poly || cfgLsbFirst != cfgNow.lsbFirst))
    |=> (result == 16'h0000)); // R8

  AST_RSVD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgPoly == 2'd3) |=> $stable(cfgNow)); // R9

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgNow.poly == POLY_C8) |-> (result[15:8] == 8'h00)); // R7

  AST_SEED_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (seedWrite && !clearReq && !cfgWrite)
    |=> (result == ((cfgNow.poly == POLY_C8) ? {8'h00, $past(seedData[7:0])}
                                             : $past(seedData)))); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!clearReq && !cfgWrite && !seedWrite && !byteValid) |=> $stable(result)); // R11
endmodule

bind crcByteEngine crcByteEngineChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clearReq   (clearReq),
  .cfgWrite   (cfgWrite),
  .cfgPoly    (cfgPoly),
  .cfgLsbFirst(cfgLsbFirst),
  .seedWrite  (seedWrite),
  .seedData   (seedData),
  .byteValid  (byteValid),
  .result     (result),
  .cfgNow     (cfgQ)
);

// File: tb/test_crcByteEngine.sv
`timescale 1ns/1ps
module test_crcByteEngine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearReq = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [1:0]  cfgPoly = 2'd0;
  logic        cfgLsbFirst = 1'b0;
  logic        seedWrite = 1'b0;
  logic [15:0] seedData = 16'h0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h0;
  logic [15:0] result;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  int mCrc = 0;
  int mPoly = 0;
  bit mLsb = 1'b0;

  always #2 clk = ~clk;

  crcByteEngine i_crcByteEngine (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .cfgWrite(cfgWrite),
    .cfgPoly(cfgPoly), .cfgLsbFirst(cfgLsbFirst), .seedWrite(seedWrite),
    .seedData(seedData), .byteValid(byteValid), .byteData(byteData), .result(result)
  );

  function automatic int refByte(int c, int b, int pSel, bit lsb);
    int w;
    int g;
    w = (pSel == 0) ? 8 : 16;
    if (lsb) begin
      g = (pSel == 0) ? 'hE0 : (pSel == 1) ? 'hA001 : 'h8408;
      c = c ^ b;
      for (int k = 0; k < 8; k++) c = (c & 1) ? ((c >> 1) ^ g) : (c >> 1);
    end else begin
      g = (pSel == 0) ? 'h07 : (pSel == 1) ? 'h8005 : 'h1021;
      c = c ^ (b << (w - 8));
      for (int k = 0; k < 8; k++) begin
        if ((c >> (w - 1)) & 1) c = ((c << 1) & ((1 << w) - 1)) ^ g;
        else c = (c << 1) & ((1 << w) - 1);
      end
    end
    return c;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    int nxt;
    bit accept;
    bit differs;
    @(posedge clk);
    nxt = mCrc;
    accept  = cfgWrite && (cfgPoly != 2'd3);
    differs = accept && ((int'(cfgPoly) != mPoly) || (cfgLsbFirst != mLsb));
    if (clearReq || differs) nxt = 0;
    else if (seedWrite) nxt = (mPoly == 0) ? (int'(seedData) & 'hFF) : int'(seedData);
    else if (byteValid) nxt = refByte(mCrc, int'(byteData), mPoly, mLsb);
    if (accept) begin
      mPoly = int'(cfgPoly);
      mLsb  = cfgLsbFirst;
    end
    mCrc = nxt;
    @(negedge clk);
    check(tag, int'(result), mCrc);
    if (mPoly == 0) check("R7 upper byte zero", int'(result[15:8]), 0);
    clearReq = 0; cfgWrite = 0; seedWrite = 0; byteValid = 0;
  endtask

  task automatic sendByte(int b, string tag);
    byteValid = 1; byteData = 8'(b); cyc(tag);
  endtask

  task automatic setCfg(int p, bit l, string tag);
    cfgWrite = 1; cfgPoly = 2'(p); cfgLsbFirst = l; cyc(tag);
  endtask

  task automatic seedWith(int v, string tag);
    seedWrite = 1; seedData = 16'(v); cyc(tag);
  endtask

  task automatic feedDigits(string tag);
    string s = "123456789";
    for (int i = 0; i < s.len(); i++) sendByte(int'(s[i]), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", int'(result), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", int'(result), 0);

    feedDigits("R2 R4 code0 msb stream");
    check("R2 code0 check value", int'(result), 'hF4);
    clearReq = 1; cyc("R6 clear");
    check("R6 cleared", int'(result), 0);

    setCfg(1, 0, "R8 change to code1");
    feedDigits("R2 code1 msb stream");
    check("R2 code1 check value", int'(result), 'hFEE8);
    setCfg(2, 0, "R8 change to code2");
    check("R8 change cleared", int'(result), 0);
    feedDigits("R2 code2 msb stream");
    check("R2 code2 check value", int'(result), 'h31C3);
    seedWith('hFFFF, "R5 seed wide");
    feedDigits("R5 seeded stream");
    check("R5 seeded check value", int'(result), 'h29B1);

    setCfg(1, 1, "R3 code1 lsb");
    feedDigits("R3 code1 lsb stream");
    check("R3 code1 lsb check value", int'(result), 'hBB3D);
    setCfg(2, 1, "R3 code2 lsb");
    feedDigits("R3 code2 lsb stream");
    check("R3 code2 lsb check value", int'(result), 'h2189);
    setCfg(0, 1, "R3 code0 lsb");
    feedDigits("R3 code0 lsb stream");

    seedWith('h1234, "R5 narrow seed");
    check("R5 narrow seed keeps low byte", int'(result), 'h34);
    setCfg(0, 1, "R8 same cfg keeps");
    check("R8 same cfg no clear", int'(result), 'h34);
    setCfg(3, 0, "R9 reserved code");
    check("R9 reserved keeps checksum", int'(result), 'h34);
    sendByte('hA5, "R9 byte after reserved uses old cfg");

    clearReq = 1; seedWrite = 1; seedData = 16'h5555; byteValid = 1; byteData = 8'h11;
    cyc("R10 clear beats seed and byte");
    check("R10 clear wins", int'(result), 0);
    seedWrite = 1; seedData = 16'h00C3; byteValid = 1; byteData = 8'h11;
    cyc("R10 seed beats byte");
    check("R10 seed wins", int'(result), 'hC3);
    cfgWrite = 1; cfgPoly = 2'd1; cfgLsbFirst = 0; seedWrite = 1; seedData = 16'hBEEF;
    cyc("R10 cfg change beats seed");
    check("R10 cfg change wins", int'(result), 0);
    seedWith('hBEEF, "R5 wide seed");
    repeat (3) cyc("R11 idle hold");
    check("R11 held value", int'(result), 'hBEEF);

    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 4) setCfg(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R8 R9 random cfg");
      else if (r < 6) seedWith(int'($urandom_range(0, 'hFFFF)), "R5 random seed");
      else if (r < 7) begin clearReq = 1; cyc("R6 random clear"); end
      else if (r < 12) cyc("R11 random idle");
      else sendByte(int'($urandom_range(0, 255)), "R4 random byte");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule